// File: doc/BRIEF.md
# DMA Trigger Conditioning Unit

This unit holds back one stage of a DMA channel until an external trigger event has arrived. It picks one line from a bank of trigger inputs and brings every line into the local clock domain through two flops. It then watches the picked line for an edge of the programmed polarity. Each qualifying edge is stored as a single pending credit, and the credit is shown to the channel sequencer as a "may proceed" grant.

The sequencer reports the start of each stage on one of four strobes: block start, repeated-block start, link load start and burst start. A 2-bit mode picks which of these strobes is gated. A gated strobe that sees the grant high uses up the credit in that same cycle. If the polarity is programmed as masked, the unit is bypassed and the grant stays high. If a second edge arrives while a credit is still unused, it is not queued; instead it sets a sticky overrun flag.

Top module: `dma_trig_gate`

## Requirements
- R1: After reset, `pending` and `overrun` are 0.
- R2: Only the input at index `cfg_sel` can create a credit. Edges on any other trigger line have no effect on `pending`.
- R3: With `cfg_pol` = 01, a rising edge on the selected line sets `pending`. The flag is seen after the third rising clock edge that follows the input change: two synchroniser stages plus the edge register. It is not seen after the second.
- R4: With `cfg_pol` = 10, a falling edge on the selected line sets `pending`, and a rising edge does not.
- R5: With `cfg_pol` = 00 or 11 (masked), `grant` is 1, `pending` is cleared on the next clock, and trigger edges neither create credits nor raise `overrun`.
- R6: When the polarity is not masked, `grant` equals `pending`.
- R7: In `cfg_mode` = 00 (block level), only `blk_start` consumes a credit; the other three strobes leave it in place.
- R8: In `cfg_mode` = 01, `rblk_start` consumes the credit when the parameter `REPEAT_EN` is 1. When `REPEAT_EN` is 0, mode 01 behaves like mode 00.
- R9: In `cfg_mode` = 10 (link level), only `link_start` consumes a credit.
- R10: In `cfg_mode` = 11 (burst level), `burst_start` consumes a credit if `cfg_swreq` is 1 or `burst_periph` is 1. A burst with both at 0 is not gated and leaves the credit in place.
- R11: A gated strobe that arrives while no credit is held has no effect. It is not remembered for a later trigger.
- R12: An edge that arrives while `pending` is 1, with no consume in that cycle, sets `overrun`. The flag stays 1 until reset. Only one credit is held, so a single consume clears `pending`.
- R13: An edge that arrives in the same cycle as a consume leaves `pending` at 1 and does not set `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_in | input | N_TRIG | Asynchronous trigger event bank |
| cfg_sel | input | SEL_W | Index of the trigger line to watch |
| cfg_pol | input | 2 | Polarity: 00 masked, 01 rising, 10 falling, 11 masked |
| cfg_mode | input | 2 | Gating level: 00 block, 01 repeated block, 10 link, 11 burst |
| cfg_swreq | input | 1 | Channel runs on software requests (memory to memory) |
| blk_start | input | 1 | First burst read of a block is about to start |
| rblk_start | input | 1 | A repeated block is about to start |
| link_start | input | 1 | A linked-list link load is about to start |
| burst_start | input | 1 | A programmed burst is about to start |
| burst_periph | input | 1 | The current burst was requested by the peripheral |
| grant | output | 1 | The gated stage may proceed |
| pending | output | 1 | One trigger credit is held |
| overrun | output | 1 | Sticky: an edge was dropped while a credit was held |

## Verification
The bench targets the exact latency through the synchroniser and the edge register. A design with one stage too few or too many would raise `pending` one cycle early or one cycle late. It checks that each mode reacts only to its own strobe, and that a burst that is neither software-driven nor peripheral-requested passes without consuming a credit. A design with the strobes mixed up would lose credits or keep stale ones. It also drives an edge in the very cycle of a consume and an edge on top of an unused credit. A wrong priority there would either drop the new credit, flag a false overrun, or stack two credits so that one consume leaves the grant high.

// File: rtl/dma_trig_gate.sv
module dma_trig_gate #(
  parameter int N_TRIG    = 64,
  parameter bit REPEAT_EN = 1'b1,
  localparam int SEL_W    = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TRIG-1:0] trig_in,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [1:0]        cfg_pol,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_swreq,
  input  logic              blk_start,
  input  logic              rblk_start,
  input  logic              link_start,
  input  logic              burst_start,
  input  logic              burst_periph,
  output logic              grant,
  output logic              pending,
  output logic              overrun
);

  localparam logic [1:0] POL_RISE   = 2'b01;
  localparam logic [1:0] POL_FALL   = 2'b10;
  localparam logic [1:0] MD_BLOCK   = 2'b00;
  localparam logic [1:0] MD_REPEAT  = 2'b01;
  localparam logic [1:0] MD_LINK    = 2'b10;
  localparam logic [1:0] MD_BURST   = 2'b11;

  logic [N_TRIG-1:0] sync_a, sync_b;
  logic              lvl_now, lvl_prev;
  logic              masked, hit, stage, consume;
  logic              pending_q, overrun_q;
  logic [1:0]        eff_mode;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_a   <= '0;
      sync_b   <= '0;
      lvl_prev <= 1'b0;
    end else begin
      sync_a   <= trig_in;
      sync_b   <= sync_a;
      lvl_prev <= lvl_now;
    end

  assign lvl_now = (int'(cfg_sel) < N_TRIG) ? sync_b[cfg_sel] : 1'b0;
  assign masked  = (cfg_pol != POL_RISE) && (cfg_pol != POL_FALL);
  assign hit     = ((cfg_pol == POL_RISE) &&  lvl_now && !lvl_prev) ||
                   ((cfg_pol == POL_FALL) && !lvl_now &&  lvl_prev);

  assign eff_mode = (cfg_mode == MD_REPEAT && !REPEAT_EN) ? MD_BLOCK : cfg_mode;

  always_comb
    case (eff_mode)
      MD_BLOCK:  stage = blk_start;
      MD_REPEAT: stage = rblk_start;
      MD_LINK:   stage = link_start;
      MD_BURST:  stage = burst_start && (cfg_swreq || burst_periph);
      default:   stage = 1'b0;
    endcase

  assign consume = stage && pending_q && !masked;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pending_q <= 1'b0;
      overrun_q <= 1'b0;
    end else if (masked) begin
      pending_q <= 1'b0;
    end else begin
      pending_q <= (pending_q && !consume) || hit;
      if (hit && pending_q && !consume) overrun_q <= 1'b1;
    end

  assign grant   = masked || pending_q;
  assign pending = pending_q;
  assign overrun = overrun_q;

  // Edge with polarity active leaves a credit on the next clock
  p_hit_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pending_q);

  // Masked polarity drops any held credit
  p_masked_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    masked |=> !pending_q);

  // A consume with no new edge empties the credit
  p_consume_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !hit) |=> !pending_q);

  // No credit appears without an edge
  p_no_credit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending_q && !hit) |=> !pending_q);

  // Dropped edge raises the flag, which then stays
  p_overrun_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && pending_q && !stage) |=> overrun_q);

  p_overrun_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_q |=> overrun_q);

  // Edge during consume keeps the credit without an overrun
  p_swap_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && consume && !overrun_q) |=> (pending_q && !overrun_q));

endmodule

// File: tb/dma_trig_gate_test.sv
module dma_trig_gate_test;
  localparam int NT = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [NT-1:0] trig = '0;
  logic [5:0]    sel = 6'd5;
  logic [1:0]    pol = 2'b01, mode = 2'b00;
  logic          swreq = 0, bper = 0, blk = 0, rblk = 0, link = 0, burst = 0;
  logic          g0, p0, o0, g1, p1, o1;

  dma_trig_gate #(.N_TRIG(NT), .REPEAT_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig), .cfg_sel(sel), .cfg_pol(pol),
    .cfg_mode(mode), .cfg_swreq(swreq), .blk_start(blk), .rblk_start(rblk),
    .link_start(link), .burst_start(burst), .burst_periph(bper),
    .grant(g0), .pending(p0), .overrun(o0));

  dma_trig_gate #(.N_TRIG(NT), .REPEAT_EN(1'b0)) uut_norep (
    .clk(clk), .rst_n(rst_n), .trig_in(trig), .cfg_sel(sel), .cfg_pol(pol),
    .cfg_mode(mode), .cfg_swreq(swreq), .blk_start(blk), .rblk_start(rblk),
    .link_start(link), .burst_start(burst), .burst_periph(bper),
    .grant(g1), .pending(p1), .overrun(o1));

  int    checks = 0, fails = 0;
  string tag = "R1";

  // behavioural reference: sample history, last seen level, one credit per copy
  logic [NT-1:0] hist[$];
  bit m_prev = 0;
  bit m_pend[2] = '{0, 0};
  bit m_ovr[2]  = '{0, 0};
  bit lvl, hitm, msk, want, cons;

  function automatic bit is_masked();
    return !(pol == 2'b01 || pol == 2'b10);
  endfunction

  function automatic bit gated(int rep);
    int m = int'(mode);
    if (m == 1 && rep == 0) m = 0;
    if (m == 0) return blk;
    if (m == 1) return rblk;
    if (m == 2) return link;
    return burst && (swreq || bper);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      m_prev = 0;
      m_pend = '{0, 0};
      m_ovr  = '{0, 0};
    end else begin
      lvl  = (hist.size() >= 2) ? hist[1][sel] : 1'b0;
      msk  = is_masked();
      hitm = !msk && ((pol == 2'b01 && lvl && !m_prev) || (pol == 2'b10 && !lvl && m_prev));
      m_prev = lvl;
      for (int r = 0; r < 2; r++) begin
        want = gated(r == 0 ? 1 : 0);
        cons = want && m_pend[r];
        if (msk) m_pend[r] = 0;
        else begin
          if (hitm && m_pend[r] && !cons) m_ovr[r] = 1;
          m_pend[r] = (m_pend[r] && !cons) || hitm;
        end
      end
      hist.push_front(trig);
      if (hist.size() > 3) void'(hist.pop_back());
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit mg0, mg1;
    mg0 = is_masked() || m_pend[0];
    mg1 = is_masked() || m_pend[1];
    chk(tag, "grant", int'(g0), int'(mg0));
    chk(tag, "pending", int'(p0), int'(m_pend[0]));
    chk(tag, "overrun", int'(o0), int'(m_ovr[0]));
    chk(tag, "norep grant", int'(g1), int'(mg1));
    chk(tag, "norep pending", int'(p1), int'(m_pend[1]));
    chk(tag, "norep overrun", int'(o1), int'(m_ovr[1]));
  endtask

  task automatic cyc(int n);
    repeat (n) begin
      @(negedge clk);
      compare();
    end
  endtask

  // put selected line at its idle level, then drive the active level
  task automatic make_edge(bit active);
    trig[sel] = ~active;
    cyc(4);
    trig[sel] = active;
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    cyc(1);
    s = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    tag = "R1";
    chk("R1", "pending after reset", int'(p0), 0);
    chk("R1", "overrun after reset", int'(o0), 0);

    tag = "R3";
    trig[5] = 1'b1;
    cyc(2);
    chk("R3", "pending two edges after rise", int'(p0), 0);
    cyc(1);
    chk("R3", "pending three edges after rise", int'(p0), 1);
    chk("R6", "grant follows pending", int'(g0), 1);

    tag = "R7";
    pulse(rblk); pulse(link); pulse(burst);
    chk("R7", "other strobes keep credit", int'(p0), 1);
    pulse(blk);
    chk("R7", "blk_start consumes", int'(p0), 0);
    chk("R6", "grant low without credit", int'(g0), 0);

    tag = "R2";
    trig[6] = 1'b1; cyc(4); trig[6] = 1'b0; cyc(4);
    chk("R2", "unselected line ignored", int'(p0), 0);

    tag = "R4";
    pol = 2'b10;
    trig[5] = 1'b0;
    cyc(3);
    chk("R4", "falling edge sets credit", int'(p0), 1);
    pulse(blk);
    trig[5] = 1'b1;
    cyc(4);
    chk("R4", "rising edge ignored", int'(p0), 0);

    tag = "R11";
    pulse(blk);
    trig[5] = 1'b0;
    cyc(3);
    chk("R11", "credit after early strobe", int'(p0), 1);
    cyc(3);
    chk("R11", "early strobe not remembered", int'(p0), 1);

    tag = "R8";
    mode = 2'b01;
    pulse(blk);
    chk("R8", "blk ignored in repeat mode", int'(p0), 1);
    chk("R8", "norep treats mode 01 as block", int'(p1), 0);
    pulse(rblk);
    chk("R8", "rblk consumes", int'(p0), 0);

    tag = "R9";
    mode = 2'b10;
    make_edge(1'b0); cyc(3);
    pulse(blk); pulse(burst);
    chk("R9", "non-link strobes keep credit", int'(p0), 1);
    pulse(link);
    chk("R9", "link_start consumes", int'(p0), 0);

    tag = "R10";
    mode = 2'b11;
    make_edge(1'b0); cyc(3);
    swreq = 0; bper = 0;
    pulse(burst);
    chk("R10", "ungated burst keeps credit", int'(p0), 1);
    bper = 1;
    pulse(burst);
    chk("R10", "peripheral burst consumes", int'(p0), 0);
    bper = 0; swreq = 1;
    make_edge(1'b0); cyc(3);
    pulse(burst);
    chk("R10", "software burst consumes", int'(p0), 0);
    swreq = 0;

    tag = "R13";
    mode = 2'b00;
    make_edge(1'b0); cyc(3);
    make_edge(1'b0);
    cyc(2);
    blk = 1'b1;
    cyc(1);
    blk = 1'b0;
    chk("R13", "edge during consume keeps credit", int'(p0), 1);
    chk("R13", "no overrun on swap", int'(o0), 0);

    tag = "R12";
    make_edge(1'b0); cyc(3);
    chk("R12", "overrun on dropped edge", int'(o0), 1);
    pulse(blk);
    chk("R12", "single credit held", int'(p0), 0);
    cyc(5);
    chk("R12", "overrun sticky", int'(o0), 1);

    tag = "R5";
    make_edge(1'b0); cyc(3);
    pol = 2'b00;
    cyc(1);
    chk("R5", "mask clears credit", int'(p0), 0);
    chk("R5", "grant high when masked", int'(g0), 1);
    trig[5] = 1'b1; cyc(4); trig[5] = 1'b0; cyc(4);
    chk("R5", "no credit when masked", int'(p0), 0);
    pol = 2'b11;
    trig[5] = 1'b1; cyc(4); trig[5] = 1'b0; cyc(4);
    chk("R5", "code 11 grant high", int'(g0), 1);
    chk("R5", "code 11 no credit", int'(p0), 0);

    tag = "R1";
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(2);
    chk("R1", "reset clears overrun", int'(o0), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule